// File: doc/BRIEF.md
# Processor Trace Status and Debug-Data Port

This block sits beside a processor core and turns its execution events into two 4-bit buses that run at full core speed and never stall the core. A status bus carries one code per cycle. The code says whether an instruction completed, whether a branch was taken, whether an exception handler was entered, or whether software asked for a trigger marker. Trace equipment outside the chip can rebuild the program flow from these codes and the program image.

A second 4-bit bus carries debug operands that software writes with a dedicated instruction. Each write holds a byte, a word or a long word. The write enters a small queue, and the block sends the operand out one nibble per cycle. A size code on the status bus comes one cycle ahead of the first nibble, so the capture side knows how many nibbles follow. If software writes faster than the port can drain, writes that find the queue full are dropped and a sticky flag is raised.

Top module: `trace_status_port`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block clears the operand queue and the overflow flag, and both `pst_out` and `ddata_out` read 4'b0000 after that edge.
- R2: Each status code appears on `pst_out` after the rising edge that samples the event inputs. A cycle with no event shows 4'b0000. A cycle with only `ev_retire` shows 4'b0001.
- R3: A sampled `ev_branch` shows 4'b0101, which marks the first instruction after a taken branch.
- R4: A sampled `ev_exception` shows 4'b1100, which marks entry into an exception handler.
- R5: A sampled `ev_marker` shows 4'b0100 for exactly the cycles in which it was sampled high.
- R6: When events coincide, the code is chosen in this order: exception, then marker, then branch, then completion.
- R7: `ddata_size` encodes the operand size as 2'b01 byte, 2'b10 word and 2'b11 long word. When the queue holds an operand, the serializer is idle, and none of exception, marker or branch is sampled, the block pops the oldest operand. It then shows its size code on `pst_out` (4'b1001 byte, 4'b1010 word, 4'b1011 long word) in place of the completion or idle code. `ddata_out` is 4'b0000 in that cycle.
- R8: In the cycles right after a size code, `ddata_out` carries the operand least-significant nibble first: 2 nibbles for a byte, 4 for a word, 8 for a long word. At all other times `ddata_out` reads 4'b0000.
- R9: The queue holds up to 4 operands and sends them out in the order they were written.
- R10: A write that arrives while the queue holds 4 operands is dropped and sets `ovf_sticky`. The flag stays set until reset.
- R11: A write with `ddata_size` equal to 2'b00 is ignored. It queues nothing and does not touch the overflow flag.
- R12: `pst_out` shows only the eight codes named in R2 to R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ev_retire | input | 1 | An ordinary instruction completed this cycle |
| ev_branch | input | 1 | First instruction after a taken branch |
| ev_exception | input | 1 | Exception handler entry |
| ev_marker | input | 1 | Software trigger-marker request |
| ev_ddata_wr | input | 1 | Software debug-data write |
| ddata_size | input | 2 | Operand size for the write (01 byte, 10 word, 11 long word) |
| ddata_val | input | DATA_W | Operand value, right-aligned |
| pst_out | output | 4 | Processor status code |
| ddata_out | output | 4 | Debug data nibble |
| ovf_sticky | output | 1 | Set once an operand has been dropped |

## Verification
Every status code is registered once, so it is due one edge after the cycle that carried its event. The bench drives inputs on the falling edge and reads the buses on the next falling edge. An operand written at edge N is queued at N. If nothing holds the serializer off, its size code is due after edge N+1, and its k-th nibble after edge N+1+k. The directed tests check each of those cycles one by one. When an exception is held high or the queue is drained back to back, the bench counts size codes over a fixed window and reads the first nibble that follows each one, so the order and the number of operands are checked without assuming where each operand starts.

// File: rtl/trc_pkg.sv
// Shared codes and helpers for the trace status port.
// Assumes the status and data buses are one nibble wide.
package trc_pkg;

    localparam int NIB_W = 4;

    typedef enum logic [3:0] {
        PST_IDLE    = 4'b0000,
        PST_SEQ     = 4'b0001,
        PST_MARK    = 4'b0100,
        PST_BRANCH  = 4'b0101,
        PST_SZ_BYTE = 4'b1001,
        PST_SZ_WORD = 4'b1010,
        PST_SZ_LONG = 4'b1011,
        PST_EXC     = 4'b1100
    } pst_code_e;

    typedef enum logic [1:0] {
        SZ_NONE = 2'b00,
        SZ_BYTE = 2'b01,
        SZ_WORD = 2'b10,
        SZ_LONG = 2'b11
    } op_size_e;

    // Number of nibbles that go out for an operand size
    function automatic int nibbles_for(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: nibbles_for = 2;
            SZ_WORD: nibbles_for = 4;
            SZ_LONG: nibbles_for = 8;
            default: nibbles_for = 0;
        endcase
    endfunction

    // Status code that announces an operand of a given size
    function automatic logic [3:0] size_code(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: size_code = PST_SZ_BYTE;
            SZ_WORD: size_code = PST_SZ_WORD;
            default: size_code = PST_SZ_LONG;
        endcase
    endfunction

endpackage

// File: rtl/trc_opq.sv
// Operand queue: a small FIFO of (size, value) pairs.
// Assumes push is only raised for a non-zero size. A push that finds the
// queue full is dropped and sets a sticky flag. Pop is only raised when
// the queue is not empty. Fullness is judged from the registered count,
// so a pop in the same cycle does not rescue a push into a full queue.
module trc_opq #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [1:0]        push_size,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [1:0]        head_size,
    output logic [DATA_W-1:0] head_data,
    output logic              empty,
    output logic              full,
    output logic [CW-1:0]     count,
    output logic              ovf
);

    logic [1:0]        size_mem [DEPTH];
    logic [DATA_W-1:0] data_mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     cnt_q;
    logic              ovf_q;
    logic              do_push;

    assign full      = (cnt_q == CW'(DEPTH));
    assign empty     = (cnt_q == '0);
    assign do_push   = push && !full;
    assign head_size = size_mem[rd_ptr];
    assign head_data = data_mem[rd_ptr];
    assign count     = cnt_q;
    assign ovf       = ovf_q;

    // Advance a pointer with wrap at DEPTH
    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        bump = (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write on accepted push
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                size_mem[i] <= 2'b00;
                data_mem[i] <= '0;
            end
        end else if (do_push) begin
            size_mem[wr_ptr] <= push_size;
            data_mem[wr_ptr] <= push_data;
        end
    end

    // Pointers, occupancy and sticky overflow
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
            ovf_q  <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (pop)     rd_ptr <= bump(rd_ptr);
            case ({do_push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
            if (push && full) ovf_q <= 1'b1;
        end
    end

endmodule

// File: rtl/trc_nibble_ser.sv
// Nibble serializer: loads one operand on start and drives it out least
// significant nibble first, one nibble per cycle, starting the cycle after
// the load. Its output is zero whenever no nibble is due.
// Assumes start is only raised while busy is low.
module trc_nibble_ser
    import trc_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int MAX_NIB = DATA_W / NIB_W,
    localparam int RW      = $clog2(MAX_NIB + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        start_size,
    input  logic [DATA_W-1:0] start_data,
    output logic              busy,
    output logic [NIB_W-1:0]  nib_out
);

    logic [DATA_W-1:0] shreg_q;
    logic [RW-1:0]     rem_q;
    logic [NIB_W-1:0]  nib_q;

    assign busy    = (rem_q != '0);
    assign nib_out = nib_q;

    // Load on start, otherwise shift one nibble out per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            rem_q   <= '0;
            nib_q   <= '0;
        end else begin
            nib_q <= busy ? shreg_q[NIB_W-1:0] : '0;
            if (start) begin
                shreg_q <= start_data;
                rem_q   <= RW'(nibbles_for(start_size));
            end else if (busy) begin
                shreg_q <= shreg_q >> NIB_W;
                rem_q   <= rem_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/trc_status_enc.sv
// Status encoder: picks one code per cycle from the core events and the
// serializer start. Exception wins over marker, marker over branch. An
// operand start shows its size code and hides a plain completion.
// Assumes start is never raised together with exception, marker or branch.
module trc_status_enc
    import trc_pkg::*;
(
    input  logic       exc,
    input  logic       mrk,
    input  logic       br,
    input  logic       ret,
    input  logic       start,
    input  logic [1:0] start_size,
    output logic [3:0] code
);

    // Fixed-priority selection of the status code
    always_comb begin
        if (exc)        code = PST_EXC;
        else if (mrk)   code = PST_MARK;
        else if (br)    code = PST_BRANCH;
        else if (start) code = size_code(start_size);
        else if (ret)   code = PST_SEQ;
        else            code = PST_IDLE;
    end

endmodule

// File: rtl/trace_status_port.sv
// Trace status and debug-data port. It registers one status code per cycle
// from the core events, and queues debug-data writes that it sends out
// nibble by nibble on a separate bus. It never back-pressures the core.
// Assumes all inputs are synchronous to clk. Reset is synchronous, active low.
module trace_status_port
    import trc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int QDEPTH = 4,
    localparam int QCW   = $clog2(QDEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_retire,
    input  logic              ev_branch,
    input  logic              ev_exception,
    input  logic              ev_marker,
    input  logic              ev_ddata_wr,
    input  logic [1:0]        ddata_size,
    input  logic [DATA_W-1:0] ddata_val,
    output logic [3:0]        pst_out,
    output logic [3:0]        ddata_out,
    output logic              ovf_sticky
);

    logic              q_push, q_empty, q_full, ser_busy, ser_start, hi_evt;
    logic [1:0]        q_head_size;
    logic [DATA_W-1:0] q_head_data;
    logic [QCW-1:0]    q_count;
    logic [3:0]        code_d, pst_q;

    assign q_push    = ev_ddata_wr && (ddata_size != SZ_NONE);
    assign hi_evt    = ev_exception || ev_marker || ev_branch;
    assign ser_start = !q_empty && !ser_busy && !hi_evt;

    trc_opq #(.DATA_W(DATA_W), .DEPTH(QDEPTH)) opq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .push_size (ddata_size),
        .push_data (ddata_val),
        .pop       (ser_start),
        .head_size (q_head_size),
        .head_data (q_head_data),
        .empty     (q_empty),
        .full      (q_full),
        .count     (q_count),
        .ovf       (ovf_sticky)
    );

    trc_nibble_ser #(.DATA_W(DATA_W)) ser_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (ser_start),
        .start_size (q_head_size),
        .start_data (q_head_data),
        .busy       (ser_busy),
        .nib_out    (ddata_out)
    );

    trc_status_enc enc_i (
        .exc        (ev_exception),
        .mrk        (ev_marker),
        .br         (ev_branch),
        .ret        (ev_retire),
        .start      (ser_start),
        .start_size (q_head_size),
        .code       (code_d)
    );

    // Register the selected status code
    always_ff @(posedge clk) begin
        if (!rst_n) pst_q <= PST_IDLE;
        else        pst_q <= code_d;
    end

    assign pst_out = pst_q;

endmodule

// File: rtl/trc_port_chk.sv
// Checker for trace_status_port: relates the event inputs to the registered
// status codes, and watches the queue occupancy and the sticky flag.
module trc_port_chk #(
    parameter int QDEPTH = 4,
    localparam int QCW   = $clog2(QDEPTH + 1)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           ev_branch,
    input logic           ev_exception,
    input logic           ev_marker,
    input logic           ev_ddata_wr,
    input logic [1:0]     ddata_size,
    input logic [3:0]     pst_out,
    input logic [3:0]     ddata_out,
    input logic           ovf_sticky,
    input logic [QCW-1:0] q_count,
    input logic           q_full
);

    AST_EXC_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        ev_exception |=> pst_out == 4'b1100); // R4

    AST_MARK_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        ev_marker && !ev_exception |=> pst_out == 4'b0100); // R5

    AST_BRANCH_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        ev_branch && !ev_exception && !ev_marker |=> pst_out == 4'b0101); // R6

    AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        pst_out inside {4'b0000, 4'b0001, 4'b0100, 4'b0101,
                        4'b1001, 4'b1010, 4'b1011, 4'b1100}); // R12

    AST_SIZE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        pst_out inside {4'b1001, 4'b1010, 4'b1011} |-> ddata_out == 4'b0000); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= QCW'(QDEPTH)); // R9

    AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ddata_wr && ddata_size != 2'b00 && q_full |=> ovf_sticky); // R10

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_sticky |=> ovf_sticky); // R10

endmodule

bind trace_status_port trc_port_chk #(.QDEPTH(QDEPTH)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_branch    (ev_branch),
    .ev_exception (ev_exception),
    .ev_marker    (ev_marker),
    .ev_ddata_wr  (ev_ddata_wr),
    .ddata_size   (ddata_size),
    .pst_out      (pst_out),
    .ddata_out    (ddata_out),
    .ovf_sticky   (ovf_sticky),
    .q_count      (q_count),
    .q_full       (q_full)
);

// File: tb/trace_status_port_tb_top.sv
`timescale 1ns/1ps
module trace_status_port_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_retire = 0, ev_branch = 0, ev_exception = 0, ev_marker = 0, ev_ddata_wr = 0;
    logic [1:0]  ddata_size = 2'b00;
    logic [31:0] ddata_val = '0;
    logic [3:0]  pst_out, ddata_out;
    logic        ovf_sticky;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    trace_status_port dut_i (
        .clk(clk), .rst_n(rst_n), .ev_retire(ev_retire), .ev_branch(ev_branch),
        .ev_exception(ev_exception), .ev_marker(ev_marker), .ev_ddata_wr(ev_ddata_wr),
        .ddata_size(ddata_size), .ddata_val(ddata_val), .pst_out(pst_out),
        .ddata_out(ddata_out), .ovf_sticky(ovf_sticky)
    );

    // {exception, marker, branch, retire, expected status}
    localparam logic [7:0] STAT_VEC [12] = '{
        8'b0000_0000,  // R2 idle
        8'b0001_0001,  // R2 completion
        8'b0010_0101,  // R3 branch
        8'b0011_0101,  // R6 branch over completion
        8'b1000_1100,  // R4 exception
        8'b1111_1100,  // R6 all events
        8'b0100_0100,  // R5 marker
        8'b0110_0100,  // R6 marker over branch
        8'b0101_0100,  // R5 marker again, one cycle each
        8'b1001_1100,  // R4 exception over completion
        8'b0000_0000,  // R2 back to idle
        8'b0001_0001   // R2 completion
    };

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_ev(input logic e, input logic m, input logic b, input logic r);
        ev_exception = e; ev_marker = m; ev_branch = b; ev_retire = r;
    endtask

    task automatic set_wr(input logic w, input logic [1:0] s, input logic [31:0] d);
        ev_ddata_wr = w; ddata_size = s; ddata_val = d;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int nmark;
        int firsts [4];
        logic take_next;
        @(negedge clk);
        // R1: reset state
        tick(); tick();
        chk("R1 pst", pst_out, 4'h0);
        chk("R1 ddata", ddata_out, 4'h0);
        chk("R1 ovf", {3'b0, ovf_sticky}, 4'h0);
        rst_n = 1'b1;

        // R2 R3 R4 R5 R6 status table
        for (int i = 0; i < 12; i++) begin
            set_ev(STAT_VEC[i][7], STAT_VEC[i][6], STAT_VEC[i][5], STAT_VEC[i][4]);
            tick();
            chk($sformatf("R2/R3/R4/R5/R6 vector %0d status", i), pst_out, STAT_VEC[i][3:0]);
            chk($sformatf("R8 vector %0d ddata quiet", i), ddata_out, 4'h0);
        end
        set_ev(0, 0, 0, 0);
        tick();

        // R7 R8: byte operand
        set_wr(1, 2'b01, 32'h0000_00A5);
        tick();
        set_wr(0, 2'b00, 0);
        chk("R7 byte no code at push", pst_out, 4'h0);
        tick();
        chk("R7 byte size code", pst_out, 4'b1001);
        chk("R7 byte quiet data", ddata_out, 4'h0);
        tick(); chk("R8 byte nibble0", ddata_out, 4'h5);
        tick(); chk("R8 byte nibble1", ddata_out, 4'hA);
        tick(); chk("R8 byte end", ddata_out, 4'h0);

        // R7 R8: long operand
        set_wr(1, 2'b11, 32'h1234_5678);
        tick();
        set_wr(0, 2'b00, 0);
        tick();
        chk("R7 long size code", pst_out, 4'b1011);
        for (int k = 0; k < 8; k++) begin
            tick();
            chk($sformatf("R8 long nibble %0d", k), ddata_out, 4'(8 - k));
        end
        tick(); chk("R8 long end", ddata_out, 4'h0);

        // R7: word deferred by branch, then shown in place of completion
        set_ev(0, 0, 1, 0);
        set_wr(1, 2'b10, 32'h0000_BEEF);
        tick();
        set_wr(0, 2'b00, 0);
        chk("R3 branch while queued", pst_out, 4'b0101);
        tick(); chk("R7 held off by branch", pst_out, 4'b0101);
        chk("R8 no data while held", ddata_out, 4'h0);
        set_ev(0, 0, 0, 1);
        tick();
        set_ev(0, 0, 0, 0);
        chk("R7 word size over completion", pst_out, 4'b1010);
        tick(); chk("R8 word nibble0", ddata_out, 4'hF);
        tick(); chk("R8 word nibble1", ddata_out, 4'hE);
        tick(); chk("R8 word nibble2", ddata_out, 4'hE);
        tick(); chk("R8 word nibble3", ddata_out, 4'hB);
        tick(); chk("R8 word end", ddata_out, 4'h0);

        // R11: zero size ignored
        set_wr(1, 2'b00, 32'hFFFF_FFFF);
        tick();
        set_wr(0, 2'b00, 0);
        nmark = 0;
        for (int k = 0; k < 12; k++) begin
            tick();
            if (pst_out != 4'h0 || ddata_out != 4'h0) nmark++;
        end
        chk("R11 zero size no output", 4'(nmark), 4'h0);
        chk("R11 zero size no overflow", {3'b0, ovf_sticky}, 4'h0);

        // R9 R10: fill while exception blocks draining, fifth write dropped
        set_ev(1, 0, 0, 0);
        for (int k = 1; k <= 5; k++) begin
            set_wr(1, 2'b11, 32'hC0DE_0000 | 32'(k));
            tick();
        end
        set_wr(0, 2'b00, 0);
        chk("R4 exception held", pst_out, 4'b1100);
        chk("R10 overflow set", {3'b0, ovf_sticky}, 4'h1);
        set_ev(0, 0, 0, 0);
        nmark = 0;
        take_next = 1'b0;
        for (int k = 0; k < 40; k++) begin
            tick();
            if (take_next && nmark <= 4) firsts[nmark-1] = int'(ddata_out);
            take_next = 1'b0;
            if (pst_out == 4'b1011) begin
                nmark++;
                take_next = 1'b1;
            end
        end
        chk("R9 four operands drained", 4'(nmark), 4'h4);
        for (int k = 0; k < 4; k++)
            chk($sformatf("R9 order entry %0d", k), 4'(firsts[k]), 4'(k + 1));
        chk("R10 overflow sticky", {3'b0, ovf_sticky}, 4'h1);

        // R1: reset in the middle of an operand
        set_wr(1, 2'b11, 32'h8765_4321);
        tick();
        set_wr(0, 2'b00, 0);
        tick(); tick();
        rst_n = 1'b0;
        tick();
        chk("R1 mid reset pst", pst_out, 4'h0);
        chk("R1 mid reset ddata", ddata_out, 4'h0);
        chk("R1 mid reset ovf", {3'b0, ovf_sticky}, 4'h0);
        rst_n = 1'b1;
        nmark = 0;
        for (int k = 0; k < 12; k++) begin
            tick();
            if (pst_out != 4'h0 || ddata_out != 4'h0) nmark++;
        end
        chk("R1 queue empty after reset", 4'(nmark), 4'h0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule